// File: doc/BRIEF.md
# Line change timestamp capture unit

The unit watches a configurable number of 32-line input groups ("slices"). Each slice keeps a record of the last level it captured on its lines. When an enabled line differs from that record, the unit writes one event into an internal queue. The event holds the value of a free-running 64-bit timestamp, the slice number, and the slice's old and new 32-bit values. Several lines that change in the same capture show up as several set bits in the XOR of the old and new values. The global line number of a bit is slice*32 plus the bit position.

Software works through a plain 32-bit read/write port. It sets up the control and per-slice enable registers, reads the head event, and removes that event with a command write. A level interrupt tells software when the queue holds at least a programmed number of events.

Top module: `evt_stamp_top`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low, the queue is empty and the timestamp counter starts at zero.
- R2: The timestamp advances by one every TICK_DIV clock cycles. With the default of 4 at 125 MHz, that is once every 32 ns. An event stores the counter value of the cycle in which it is written. The head timestamp reads as a high word at 0x04 and a low word at 0x08.
- R3: Take a slice with global enable set. When the enabled bits of its inputs differ from its stored value, one event is written. The old value reads at 0x14 and the new value reads at 0x10. Every changed enabled bit shows in their XOR, and more than one bit may be set.
- R4: Lines whose enable bit is 0 never cause an event and never appear in an event's XOR. While global enable is 0, no events are written and each stored value follows its inputs. Setting global enable again then produces no event.
- R5: The head event's slice number reads in bits 23:16 of 0x0C, and the other bits read 0. Slices that need a capture in the same cycle are written one per cycle in ascending slice order.
- R6: Register 0x20 reports the number of queued events in bits 15:8. While the queue is empty, the head registers at 0x04, 0x08, 0x0C, 0x10 and 0x14 read zero.
- R7: A write with bit 0 set to 0x1C removes the head event. Such a write to an empty queue has no effect.
- R8: An event that arrives while the queue holds FIFO_DEPTH entries is dropped, and it sets a sticky flag in bit 0 of 0x20. Writing 1 to that bit clears the flag. The stored value still takes the dropped capture.
- R9: `irq_o` is high exactly while global enable, interrupt enable and (occupancy >= threshold) all hold. The output comes straight from registered state.
- R10: Control at 0x00 holds global enable in bit 0, interrupt enable in bit 1 and the threshold in bits 15:8. All its other bits read 0. The enable register of slice N sits at 0x40 + 0x20*N, and bit k of it enables line k. Addresses not listed here read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | NUM_SLICES*32 | Synchronised input lines, slice s at bits s*32+31:s*32 |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Level interrupt from the occupancy threshold |

## Verification
A wrong stored slice value shows up one capture later in the old/new value pair of the head event. It can also show as a missing or extra event, which moves the occupancy field in the very next cycle. A wrong occupancy count shows at once in the status register and in the interrupt level, and the bench compares both on every clock. A slip in the timestamp divider shows as a wrong spacing between two events written a known number of cycles apart. An error in the arbitration order shows as slice numbers out of order across consecutive pops.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
    localparam int SLICE_W = 32;
    localparam int ADDR_W  = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_TSH  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_TSL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_CUR  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_PREV = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_EN0  = 12'h040;
    localparam int EN_STRIDE_LG = 5;

    typedef struct packed {
        logic [63:0]        stamp;
        logic [7:0]         slice;
        logic [SLICE_W-1:0] prev;
        logic [SLICE_W-1:0] cur;
    } evt_entry_t;
endpackage

// File: rtl/evt_stamp_tick.sv
module evt_stamp_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [63:0] stamp_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [63:0]      stamp;
    } tick_st_t;

    tick_st_t tick_d, tick_q;

    always_comb begin
        tick_d = tick_q;
        if (tick_q.div == DIV_W'(TICK_DIV - 1)) begin
            tick_d.div   = '0;
            tick_d.stamp = tick_q.stamp + 64'd1;
        end else begin
            tick_d.div = tick_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign stamp_o = tick_q.stamp;
endmodule

// File: rtl/evt_stamp_slice.sv
module evt_stamp_slice
    import evt_stamp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLICE_W-1:0] lines_i,
    input  logic [SLICE_W-1:0] en_mask,
    input  logic               run,
    input  logic               grant,
    output logic               req,
    output logic [SLICE_W-1:0] prev_o,
    output logic [SLICE_W-1:0] next_o
);
    typedef struct packed {
        logic [SLICE_W-1:0] last;
    } slice_st_t;

    slice_st_t sl_d, sl_q;

    always_comb begin
        sl_d   = sl_q;
        prev_o = sl_q.last;
        next_o = (sl_q.last & ~en_mask) | (lines_i & en_mask);
        req    = run && (|((lines_i ^ sl_q.last) & en_mask));
        if (!run)       sl_d.last = lines_i;
        else if (grant) sl_d.last = next_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end
endmodule

// File: rtl/evt_stamp_fifo.sv
module evt_stamp_fifo
    import evt_stamp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  evt_entry_t       entry_i,
    input  logic             pop,
    output evt_entry_t       head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             drop_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t   ff_d, ff_q;
    evt_entry_t mem [DEPTH];
    logic       push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        ff_d    = ff_q;
        pop_ok  = pop && (ff_q.cnt != '0);
        push_ok = push && (ff_q.cnt != CNT_W'(DEPTH));
        drop_o  = push && (ff_q.cnt == CNT_W'(DEPTH));
        if (pop_ok)  ff_d.rd = bump(ff_q.rd);
        if (push_ok) ff_d.wr = bump(ff_q.wr);
        ff_d.cnt = ff_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        head_o   = (ff_q.cnt == '0) ? '0 : mem[ff_q.rd];
        count_o  = ff_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[ff_q.wr] <= entry_i;
    end
endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top
    import evt_stamp_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    parameter int FIFO_DEPTH = 8,
    parameter int TICK_DIV   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLICES*SLICE_W-1:0] lines_i,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wen,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          irq_o
);
    localparam int SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic                                 run;
        logic                                 ien;
        logic [7:0]                           thr;
        logic                                 ovf;
        logic [NUM_SLICES-1:0][SLICE_W-1:0]   en;
    } regs_st_t;

    regs_st_t          regs_d, regs_q;
    logic [63:0]       stamp;
    logic [NUM_SLICES-1:0] req, grant;
    logic [SLICE_W-1:0] prev_arr [NUM_SLICES];
    logic [SLICE_W-1:0] next_arr [NUM_SLICES];
    logic [SEL_W-1:0]  gsel;
    logic              push_try, pop_cmd, fifo_drop;
    evt_entry_t        push_entry, head;
    logic [CNT_W-1:0]  occ;

    function automatic logic [ADDR_W-1:0] en_addr(input int s);
        return OFS_EN0 + ADDR_W'(s << EN_STRIDE_LG);
    endfunction

    evt_stamp_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .stamp_o(stamp)
    );

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        evt_stamp_slice u_slice (
            .clk(clk), .rst_n(rst_n),
            .lines_i(lines_i[s*SLICE_W +: SLICE_W]),
            .en_mask(regs_q.en[s]),
            .run(regs_q.run),
            .grant(grant[s]),
            .req(req[s]),
            .prev_o(prev_arr[s]),
            .next_o(next_arr[s])
        );
    end

    // lowest-numbered requesting slice wins the single push slot
    always_comb begin
        gsel     = '0;
        push_try = 1'b0;
        for (int s = NUM_SLICES - 1; s >= 0; s--) begin
            if (req[s]) begin
                gsel     = SEL_W'(s);
                push_try = 1'b1;
            end
        end
        grant            = push_try ? (NUM_SLICES'(1) << gsel) : '0;
        push_entry.stamp = stamp;
        push_entry.slice = 8'(gsel);
        push_entry.prev  = prev_arr[gsel];
        push_entry.cur   = next_arr[gsel];
    end

    assign pop_cmd = bus_wen && (bus_addr == OFS_CMD) && bus_wdata[0];

    evt_stamp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_try), .entry_i(push_entry),
        .pop(pop_cmd), .head_o(head),
        .count_o(occ), .drop_o(fifo_drop)
    );

    always_comb begin
        regs_d = regs_q;
        if (bus_wen && bus_addr == OFS_CTRL) begin
            regs_d.run = bus_wdata[0];
            regs_d.ien = bus_wdata[1];
            regs_d.thr = bus_wdata[15:8];
        end
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (bus_wen && bus_addr == en_addr(s)) regs_d.en[s] = bus_wdata;
        end
        regs_d.ovf = (regs_q.ovf && !(bus_wen && bus_addr == OFS_STAT && bus_wdata[0]))
                     || fifo_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata = {16'h0, regs_q.thr, 6'h0, regs_q.ien, regs_q.run};
            OFS_TSH:  bus_rdata = head.stamp[63:32];
            OFS_TSL:  bus_rdata = head.stamp[31:0];
            OFS_SRC:  bus_rdata = {8'h0, head.slice, 16'h0};
            OFS_CUR:  bus_rdata = head.cur;
            OFS_PREV: bus_rdata = head.prev;
            OFS_STAT: bus_rdata = {16'h0, 8'(occ), 7'h0, regs_q.ovf};
            default: begin
                for (int s = 0; s < NUM_SLICES; s++) begin
                    if (bus_addr == en_addr(s)) bus_rdata = regs_q.en[s];
                end
            end
        endcase
    end

    assign irq_o = regs_q.run && regs_q.ien && (32'(occ) >= 32'(regs_q.thr));
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] occ,
    input logic             push_try,
    input logic             ovf,
    input logic             irq,
    input logic [7:0]       thr
);
    assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (int'($past(occ)) == DEPTH && $past(push_try)));

    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && !push_try) |=> occ == '0);

    assert_occ_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) == int'($past(occ))) || (int'(occ) == int'($past(occ)) + 1)
        || (int'(occ) + 1 == int'($past(occ))));

    assert_irq_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (occ != '0 || thr == 8'h0));
endmodule

bind evt_stamp_top evt_stamp_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .occ(occ), .push_try(push_try),
    .ovf(regs_q.ovf), .irq(irq_o), .thr(regs_q.thr)
);

// File: tb/tb_evt_stamp_top.sv
module tb_evt_stamp_top;
    localparam int NS = 3;
    localparam int DEPTH = 8;
    localparam int TDIV = 4;
    localparam logic [11:0] A_STAT = 12'h020;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS*32-1:0] lines = '0;
    logic [11:0] bus_addr = A_STAT;
    logic bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evt_stamp_top #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH), .TICK_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    typedef struct {
        longint unsigned ts;
        int              sl;
        bit [31:0]       pv;
        bit [31:0]       cv;
    } ev_t;

    ev_t m_q[$];
    bit [31:0] m_last[NS];
    bit [31:0] m_en[NS];
    bit m_run, m_ien, m_ovf;
    bit [7:0] m_thr;
    longint unsigned m_ts;
    int m_div;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge from pre-edge inputs
    always @(posedge clk) begin
        ev_t e;
        bit found, popv;
        bit [31:0] ln;
        if (!rst_n) begin
            m_q.delete();
            for (int s = 0; s < NS; s++) begin m_last[s] = 0; m_en[s] = 0; end
            m_run = 0; m_ien = 0; m_ovf = 0; m_thr = 0; m_ts = 0; m_div = 0;
        end else begin
            found = 0;
            for (int s = 0; s < NS; s++) begin
                ln = lines[s*32 +: 32];
                if (!m_run) m_last[s] = ln;
                else if (!found && (((ln ^ m_last[s]) & m_en[s]) != 0)) begin
                    found = 1;
                    e.ts = m_ts; e.sl = s; e.pv = m_last[s];
                    e.cv = (m_last[s] & ~m_en[s]) | (ln & m_en[s]);
                    m_last[s] = e.cv;
                end
            end
            popv = bus_wen && bus_addr == 12'h01C && bus_wdata[0] && m_q.size() > 0;
            if (bus_wen && bus_addr == A_STAT && bus_wdata[0]) m_ovf = 0;
            if (found && m_q.size() == DEPTH) m_ovf = 1;
            else if (found) begin
                if (popv) void'(m_q.pop_front());
                m_q.push_back(e);
                popv = 0;
            end
            if (popv) void'(m_q.pop_front());
            if (bus_wen && bus_addr == 12'h000) begin
                m_run = bus_wdata[0]; m_ien = bus_wdata[1]; m_thr = bus_wdata[15:8];
            end
            for (int s = 0; s < NS; s++)
                if (bus_wen && bus_addr == 12'h040 + 12'(s * 32)) m_en[s] = bus_wdata;
            if (m_div == TDIV - 1) begin m_div = 0; m_ts++; end
            else m_div++;
        end
    end

    // per-clock comparison, away from both edges
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R9 irq level", irq_o,
                (m_run && m_ien && m_q.size() >= int'(m_thr)) ? 1'b1 : 1'b0);
            if (bus_addr == A_STAT && !bus_wen)
                chk("R6 status occupancy/overflow", bus_rdata,
                    {16'h0, 8'(m_q.size()), 7'h0, m_ovf});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = A_STAT;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = A_STAT;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_lines(input int s, input logic [31:0] v);
        @(negedge clk);
        lines[s*32 +: 32] = v;
    endtask

    task automatic check_head(output longint unsigned ts_seen);
        logic [31:0] h, l, src, cur, prv;
        ev_t x;
        rd(12'h004, h); rd(12'h008, l); rd(12'h00C, src);
        rd(12'h010, cur); rd(12'h014, prv);
        ts_seen = {h, l};
        if (m_q.size() == 0) begin
            chk("R6 empty head zero", {h, l, src, cur, prv} == '0, 1'b1);
        end else begin
            x = m_q[0];
            chk("R2 head timestamp", {h, l}, x.ts);
            chk("R5 head slice field", src, {8'h0, 8'(x.sl), 16'h0});
            chk("R3 head current", cur, x.cv);
            chk("R3 head previous", prv, x.pv);
        end
    endtask

    initial begin
        logic [31:0] v;
        longint unsigned t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(12'h000, v); chk("R1 control after reset", v, 32'h0);
        rd(12'h040, v); chk("R1 enable after reset", v, 32'h0);
        rd(A_STAT, v);  chk("R1 status after reset", v, 32'h0);
        chk("R1 irq after reset", irq_o, 1'b0);
        check_head(t0);

        // R10 register layout
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, v); chk("R10 control mask", v, 32'h0000_FF03);
        wr(12'h060, 32'hA5A5_0001);
        rd(12'h060, v); chk("R10 slice1 enable at 0x60", v, 32'hA5A5_0001);
        rd(12'h018, v); chk("R10 unmapped reads zero", v, 32'h0);
        wr(12'h060, 32'h0);
        wr(12'h000, 32'h0000_0103);       // run, irq en, threshold 1
        wr(12'h040, 32'h0000_00FF);
        wr(12'h080, 32'hFFFF_FFFF);

        // R3 two bits together in one event
        set_lines(0, 32'h0000_0009);
        idle(2);
        rd(A_STAT, v); chk("R3 one event for two bits", v[15:8], 8'd1);
        check_head(t0);
        chk("R3 xor of prev/cur", m_q.size() > 0 ? (m_q[0].pv ^ m_q[0].cv) : 0, 32'h9);
        wr(12'h01C, 32'h1);

        // R4 disabled bit alone, then mixed
        set_lines(0, 32'h0000_0109);
        idle(3);
        rd(A_STAT, v); chk("R4 disabled line ignored", v[15:8], 8'd0);
        set_lines(0, 32'h0000_010D);
        idle(2);
        check_head(t0);
        rd(12'h010, v);
        begin
            logic [31:0] p;
            rd(12'h014, p);
            chk("R4 xor shows only enabled bit", v ^ p, 32'h4);
        end
        wr(12'h01C, 32'h1);

        // R5 simultaneous slices, ascending order
        @(negedge clk);
        lines[0*32 +: 32] = 32'h0000_010F;
        lines[1*32 +: 32] = 32'hFFFF_0000;
        lines[2*32 +: 32] = 32'h8000_0000;
        idle(3);
        rd(A_STAT, v); chk("R5 two events from same cycle", v[15:8], 8'd2);
        rd(12'h00C, v); chk("R5 first is slice 0", v, 32'h0000_0000);
        check_head(t0);
        wr(12'h01C, 32'h1);
        rd(12'h00C, v); chk("R5 second is slice 2", v, 32'h0002_0000);
        check_head(t1);
        chk("R5 consecutive pushes", (t1 - t0) <= 1, 1'b1);
        wr(12'h01C, 32'h1);
        // R7 pop on empty
        wr(12'h01C, 32'h1);
        rd(A_STAT, v); chk("R7 pop on empty ignored", v[15:8], 8'd0);

        // R2 spacing of 8 cycles gives 2 ticks
        set_lines(2, 32'h8000_0001);
        idle(7);
        set_lines(2, 32'h8000_0000);
        idle(2);
        check_head(t0);
        wr(12'h01C, 32'h1);
        check_head(t1);
        chk("R2 stamp spacing", t1 - t0, 64'd2);
        wr(12'h01C, 32'h1);

        // R9 threshold 2
        wr(12'h000, 32'h0000_0203);
        set_lines(2, 32'h8000_0010);
        idle(2);
        chk("R9 below threshold low", irq_o, 1'b0);
        set_lines(2, 32'h8000_0000);
        idle(2);
        chk("R9 at threshold high", irq_o, 1'b1);
        wr(12'h000, 32'h0000_0201);
        chk("R9 gated by interrupt enable", irq_o, 1'b0);
        wr(12'h000, 32'h0000_0203);
        wr(12'h01C, 32'h1);
        chk("R9 falls after pop", irq_o, 1'b0);
        wr(12'h01C, 32'h1);

        // R8 overflow
        for (int i = 0; i < DEPTH + 2; i++) begin
            @(negedge clk);
            lines[2*32 + 5] = ~lines[2*32 + 5];
        end
        idle(2);
        rd(A_STAT, v);
        chk("R8 full occupancy", v[15:8], 8'(DEPTH));
        chk("R8 sticky overflow set", v[0], 1'b1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R8 overflow cleared by write", v[0], 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            check_head(t0);
            wr(12'h01C, 32'h1);
        end
        rd(A_STAT, v); chk("R7 drained", v[15:8], 8'd0);

        // R4 global disable then re-enable
        wr(12'h000, 32'h0000_0102);
        set_lines(0, 32'h0000_00F0);
        set_lines(2, 32'h1234_5678);
        idle(3);
        rd(A_STAT, v); chk("R4 no events while off", v[15:8], 8'd0);
        wr(12'h000, 32'h0000_0103);
        idle(3);
        rd(A_STAT, v); chk("R4 no event on re-enable", v[15:8], 8'd0);

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule